// File: doc/BRIEF.md
# Serial Command/Data Byte Receiver with Counted Bursts

This block is the write-only serial front end of a display controller. A host shifts bytes in on a data line, one bit per rising edge of a serial clock, most significant bit first, while an active-low select is held low. All serial inputs are brought into the system clock domain through synchronisers. Every completed byte leaves the block as a one-cycle strobe, together with the byte and a tag that marks it as display data or as a command.

Two framing modes are chosen by a strap input. With the strap high (four-wire mode), a register-select pin decides the tag of each byte. With the strap low (three-wire mode), there is no such pin and the tag is carried in band. Each byte is a command until the direction code 0xE8 arrives. The next byte is then a length L, and exactly L+1 bytes of display data follow. After that the block returns to commands. Releasing the select during the length or data phase abandons the burst. A column counter steps once per data byte and wraps at the width of the display.

The controller states are named ST_CMD, ST_LEN and ST_DATA. The transitions between them are:
- ST_CMD→ST_LEN on the direction code.
- ST_LEN→ST_DATA on any byte.
- ST_DATA→ST_DATA while bytes remain.
- ST_DATA→ST_CMD on the last counted byte.
- ST_LEN/ST_DATA→ST_CMD when the select is released.
- Any state→ST_CMD while four-wire mode is strapped.

Top module: `spi_cmd_data_rx`

## Requirements
- R1: Bits are taken from `sid` on rising edges of `sclk`, MSB first. The eighth edge completes a byte, which appears on `rx_byte` with `rx_valid` high for exactly one `clk` cycle.
- R2: While `cs_n` is high, the partial byte and the bit count are cleared. After reselection, the next eight edges form a fresh byte and earlier partial bits never appear.
- R3: With `four_wire`=1, a byte is tagged data (`rx_is_data`=1) when `rs` is high as it completes, and command (`rx_is_data`=0) when `rs` is low.
- R4: With `four_wire`=0 and no burst active, every byte other than 0xE8 is emitted as a command.
- R5: In three-wire command state, the byte 0xE8 and the length byte that follows it are consumed internally and produce no `rx_valid` pulse.
- R6: A length byte of value L (8 bits, unsigned) makes the next L+1 bytes data. So 0 gives one byte and 127 gives 128 bytes. The byte after them is a command again.
- R7: If `cs_n` goes high while a length or data byte is awaited, the burst is abandoned. The next complete byte is treated as a command.
- R8: `col_addr` steps by one, one cycle after each data strobe, and wraps from NUM_COLS-1 to 0. Command strobes leave it unchanged.
- R9: The value 0xE8 has no special meaning inside a data burst, or in four-wire mode with `rs` low. There it is emitted as an ordinary data byte or command byte.
- R10: After reset, `rx_valid` is 0 and `col_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low (asynchronous) |
| sclk | input | 1 | Serial bit clock (asynchronous) |
| sid | input | 1 | Serial data in, MSB first |
| rs | input | 1 | Data/command select, used in four-wire mode |
| four_wire | input | 1 | Mode strap: 1 = four-wire, 0 = three-wire counted mode |
| rx_valid | output | 1 | One-cycle strobe for a completed byte |
| rx_is_data | output | 1 | 1 = display data, 0 = command, valid with `rx_valid` |
| rx_byte | output | 8 | Received byte |
| col_addr | output | $clog2(NUM_COLS) | Column position advanced by data bytes |

## Verification
The bench builds the block with NUM_COLS=16 and SYNC_STAGES=2. With 16 columns, the column wrap is crossed several times by short bursts, and a single 128-byte burst (length 127) must bring the counter back to its start value. It also drives bursts with length 0 and 2, data containing 0xE8, a select released mid-byte and mid-burst, and four-wire traffic with both tags.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_LEN  = 2'd1,
        ST_DATA = 2'd2
    } rx_state_e;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
    parameter int WIDTH   = 4,
    parameter int STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sid_s,
    output logic              done,
    output logic [BYTE_W-1:0] byte_q
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sclk_d;
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              rise;

    assign rise = sclk_s & ~sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sh     <= '0;
            cnt    <= '0;
            done   <= 1'b0;
            byte_q <= '0;
        end else begin
            sclk_d <= sclk_s;
            done   <= 1'b0;
            if (cs_n_s) begin
                sh  <= '0;
                cnt <= '0;
            end else if (rise) begin
                sh <= {sh[BYTE_W-2:0], sid_s};
                if (cnt == CNT_W'(BYTE_W - 1)) begin
                    cnt    <= '0;
                    done   <= 1'b1;
                    byte_q <= {sh[BYTE_W-2:0], sid_s};
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_rx_ctrl.sv
module spi_rx_ctrl
    import spi_rx_pkg::*;
#(
    parameter int          BYTE_W   = 8,
    parameter logic [7:0]  DIR_CODE = 8'hE8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              four_wire,
    input  logic              cs_n_s,
    input  logic              rs_s,
    input  logic              done,
    input  logic [BYTE_W-1:0] byte_q,
    output logic              rx_valid,
    output logic              rx_is_data,
    output logic [BYTE_W-1:0] rx_byte,
    output rx_state_e         state,
    output logic [BYTE_W-1:0] remain
);
    rx_state_e         state_n;
    logic [BYTE_W-1:0] remain_n;
    logic              emit;
    logic              emit_data;

    always_comb begin
        state_n   = state;
        remain_n  = remain;
        emit      = 1'b0;
        emit_data = 1'b0;
        if (four_wire) begin
            state_n   = ST_CMD;
            emit      = done;
            emit_data = rs_s;
        end else if (done) begin
            unique case (state)
                ST_CMD: begin
                    if (byte_q == BYTE_W'(DIR_CODE)) state_n = ST_LEN;
                    else                             emit    = 1'b1;
                end
                ST_LEN: begin
                    remain_n = byte_q;
                    state_n  = ST_DATA;
                end
                ST_DATA: begin
                    emit      = 1'b1;
                    emit_data = 1'b1;
                    if (remain == '0) state_n  = ST_CMD;
                    else              remain_n = remain - 1'b1;
                end
                default: state_n = ST_CMD;
            endcase
        end else if (cs_n_s) begin
            state_n = ST_CMD;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_CMD;
            remain <= '0;
        end else begin
            state  <= state_n;
            remain <= remain_n;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid   <= 1'b0;
            rx_is_data <= 1'b0;
            rx_byte    <= '0;
        end else begin
            rx_valid   <= emit;
            rx_is_data <= emit & emit_data;
            if (emit) rx_byte <= byte_q;
        end
    end
endmodule

// File: rtl/spi_rx_colctr.sv
module spi_rx_colctr #(
    parameter int NUM_COLS = 128,
    localparam int COL_W   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [COL_W-1:0] col
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              col <= '0;
        else if (step) begin
            if (col == COL_W'(NUM_COLS - 1))     col <= '0;
            else                                 col <= col + 1'b1;
        end
    end
endmodule

// File: rtl/spi_cmd_data_rx.sv
module spi_cmd_data_rx #(
    parameter int         NUM_COLS    = 128,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] DIR_CODE    = 8'hE8,
    localparam int        BYTE_W      = 8,
    localparam int        COL_W       = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sid,
    input  logic              rs,
    input  logic              four_wire,
    output logic              rx_valid,
    output logic              rx_is_data,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [COL_W-1:0]  col_addr
);
    import spi_rx_pkg::*;

    logic              cs_n_s, sclk_s, sid_s, rs_s;
    logic              done;
    logic [BYTE_W-1:0] byte_q;
    rx_state_e         state;
    logic [BYTE_W-1:0] remain;

    spi_rx_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({cs_n, sclk, sid, rs}),
        .q   ({cs_n_s, sclk_s, sid_s, rs_s})
    );

    spi_rx_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n_s (cs_n_s),
        .sclk_s (sclk_s),
        .sid_s  (sid_s),
        .done   (done),
        .byte_q (byte_q)
    );

    spi_rx_ctrl #(.BYTE_W(BYTE_W), .DIR_CODE(DIR_CODE)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .four_wire  (four_wire),
        .cs_n_s     (cs_n_s),
        .rs_s       (rs_s),
        .done       (done),
        .byte_q     (byte_q),
        .rx_valid   (rx_valid),
        .rx_is_data (rx_is_data),
        .rx_byte    (rx_byte),
        .state      (state),
        .remain     (remain)
    );

    spi_rx_colctr #(.NUM_COLS(NUM_COLS)) u_col (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rx_valid & rx_is_data),
        .col   (col_addr)
    );
endmodule

// File: rtl/spi_rx_checker.sv
module spi_rx_checker
    import spi_rx_pkg::*;
#(
    parameter int NUM_COLS = 128,
    localparam int COL_W   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             four_wire,
    input logic             cs_n_s,
    input logic             rx_valid,
    input logic             rx_is_data,
    input logic [COL_W-1:0] col_addr,
    input rx_state_e        state
);
    // R2: two cycles deselected leave no strobe
    a_r2_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n_s, 2) && $past(cs_n_s)) |-> !rx_valid);

    // R3: four-wire strap keeps the counted machine idle
    a_r3_fourwire_idle: assert property (@(posedge clk) disable iff (!rst_n)
        four_wire |=> state == ST_CMD);

    // R5: the length byte never yields a strobe
    a_r5_len_silent: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(state) != ST_LEN);

    // R6: three-wire data only comes from the data phase
    a_r6_data_from_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(four_wire) && rx_valid && rx_is_data) |-> $past(state) == ST_DATA);

    // R7: held deselect returns to command state
    a_r7_abort_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (!four_wire && cs_n_s && $past(cs_n_s)) |=> state == ST_CMD);

    // R8: column steps with wrap on data, holds otherwise
    a_r8_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_is_data) |=>
        col_addr == (($past(col_addr) == COL_W'(NUM_COLS - 1)) ? '0 : $past(col_addr) + 1'b1));

    a_r8_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_is_data) |=> $stable(col_addr));
endmodule

bind spi_cmd_data_rx spi_rx_checker #(.NUM_COLS(NUM_COLS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .four_wire  (four_wire),
    .cs_n_s     (cs_n_s),
    .rx_valid   (rx_valid),
    .rx_is_data (rx_is_data),
    .col_addr   (col_addr),
    .state      (state)
);

// File: tb/tb_spi_cmd_data_rx.sv
module tb_spi_cmd_data_rx;
    localparam int NCOL  = 16;
    localparam int COL_W = $clog2(NCOL);

    logic clk = 0, rst_n = 0;
    logic cs_n = 1, sclk = 0, sid = 0, rs = 0, four_wire = 0;
    logic             rx_valid, rx_is_data;
    logic [7:0]       rx_byte;
    logic [COL_W-1:0] col_addr;

    int n_chk = 0, n_bad = 0;
    int ev_n = 0;
    logic [7:0] ev_byte [512];
    logic       ev_data [512];
    int exp_col = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    spi_cmd_data_rx #(.NUM_COLS(NCOL), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sid(sid), .rs(rs),
        .four_wire(four_wire), .rx_valid(rx_valid), .rx_is_data(rx_is_data),
        .rx_byte(rx_byte), .col_addr(col_addr)
    );

    // event monitor, samples away from the active edge
    always @(negedge clk) begin
        if (rst_n && rx_valid && ev_n < 512) begin
            ev_byte[ev_n] = rx_byte;
            ev_data[ev_n] = rx_is_data;
            ev_n++;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic send_bits(logic [7:0] v, int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sid = v[i];
            wait_clk(4);
            sclk = 1;
            wait_clk(4);
            sclk = 0;
        end
    endtask

    task automatic send_byte(logic [7:0] v, logic rsv);
        rs = rsv;
        send_bits(v, 8);
    endtask

    task automatic select();
        cs_n = 0;
        wait_clk(4);
    endtask

    task automatic deselect();
        wait_clk(8);
        cs_n = 1;
        wait_clk(8);
    endtask

    task automatic expect_ev(int idx, logic [7:0] b, logic d, string tag);
        check({tag, " byte"}, int'(ev_byte[idx]), int'(b));
        check({tag, " tag"},  int'(ev_data[idx]), int'(d));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 rx_valid after reset", int'(rx_valid), 0);
        check("R10 col_addr after reset", int'(col_addr), 0);
    endtask

    task automatic t_four_wire();
        int base = ev_n;
        four_wire = 1;
        wait_clk(4);
        select();
        send_byte(8'hA5, 1);
        send_byte(8'h3C, 0);
        send_byte(8'hE8, 0);
        deselect();
        four_wire = 0;
        wait_clk(4);
        check("R3 four-wire event count", ev_n - base, 3);
        expect_ev(base,     8'hA5, 1, "R1 R3 rs high data");
        expect_ev(base + 1, 8'h3C, 0, "R3 rs low command");
        expect_ev(base + 2, 8'hE8, 0, "R9 0xE8 four-wire command");
        exp_col = (exp_col + 1) % NCOL;
        @(negedge clk);
        check("R8 col after four-wire", int'(col_addr), exp_col);
    endtask

    task automatic t_plain_cmds();
        int base = ev_n;
        select();
        send_byte(8'h81, 1);
        send_byte(8'h7E, 1);
        deselect();
        check("R4 command count", ev_n - base, 2);
        expect_ev(base,     8'h81, 0, "R4 cmd 0x81");
        expect_ev(base + 1, 8'h7E, 0, "R4 cmd 0x7E");
        @(negedge clk);
        check("R8 col unchanged by commands", int'(col_addr), exp_col);
    endtask

    task automatic t_burst3();
        int base = ev_n;
        select();
        send_byte(8'hE8, 0);
        send_byte(8'h02, 0);
        wait_clk(6);
        check("R5 no strobe for 0xE8 and length", ev_n - base, 0);
        send_byte(8'h11, 0);
        send_byte(8'h22, 0);
        send_byte(8'hE8, 0);
        send_byte(8'h55, 0);
        deselect();
        check("R6 burst L=2 event count", ev_n - base, 4);
        expect_ev(base,     8'h11, 1, "R6 burst byte0");
        expect_ev(base + 1, 8'h22, 1, "R6 burst byte1");
        expect_ev(base + 2, 8'hE8, 1, "R9 0xE8 inside burst");
        expect_ev(base + 3, 8'h55, 0, "R6 command after burst");
        exp_col = (exp_col + 3) % NCOL;
        @(negedge clk);
        check("R8 col after burst of 3", int'(col_addr), exp_col);
    endtask

    task automatic t_burst1();
        int base = ev_n;
        select();
        send_byte(8'hE8, 0);
        send_byte(8'h00, 0);
        send_byte(8'h99, 0);
        send_byte(8'hAA, 0);
        deselect();
        check("R6 L=0 event count", ev_n - base, 2);
        expect_ev(base,     8'h99, 1, "R6 L=0 single data");
        expect_ev(base + 1, 8'hAA, 0, "R6 L=0 then command");
        exp_col = (exp_col + 1) % NCOL;
    endtask

    task automatic t_partial();
        int base = ev_n;
        select();
        send_bits(8'hFF, 3);
        deselect();
        select();
        send_byte(8'h5A, 0);
        deselect();
        check("R2 one byte after partial", ev_n - base, 1);
        expect_ev(base, 8'h5A, 0, "R2 fresh alignment");
    endtask

    task automatic t_abort();
        int base = ev_n;
        select();
        send_byte(8'hE8, 0);
        send_byte(8'h05, 0);
        send_byte(8'h01, 0);
        send_bits(8'hC0, 4);
        deselect();
        select();
        send_byte(8'h77, 0);
        deselect();
        check("R7 abort event count", ev_n - base, 2);
        expect_ev(base,     8'h01, 1, "R7 data before abort");
        expect_ev(base + 1, 8'h77, 0, "R7 command after abort");
        exp_col = (exp_col + 1) % NCOL;
        @(negedge clk);
        check("R8 col after abort", int'(col_addr), exp_col);
    endtask

    task automatic t_long_burst();
        int base = ev_n;
        int bad = 0;
        select();
        send_byte(8'hE8, 0);
        send_byte(8'd127, 0);
        for (int i = 0; i < 128; i++) send_byte(8'(i * 3), 0);
        send_byte(8'h42, 0);
        deselect();
        check("R6 L=127 event count", ev_n - base, 129);
        for (int i = 0; i < 128; i++)
            if (ev_byte[base + i] != 8'(i * 3) || ev_data[base + i] != 1'b1) bad++;
        check("R6 L=127 128 data bytes intact", bad, 0);
        expect_ev(base + 128, 8'h42, 0, "R6 command after 128 data");
        exp_col = (exp_col + 128) % NCOL;
        @(negedge clk);
        check("R8 col after 128 data (wraps)", int'(col_addr), exp_col);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1;
        wait_clk(4);
        t_reset();
        t_four_wire();
        t_plain_cmds();
        t_burst3();
        t_burst1();
        t_partial();
        t_abort();
        t_long_burst();
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule